// File: doc/BRIEF.md
# Bus-Matching Word Packer and Unpacker

This block sits between two 36-bit internal FIFO ports and one external data port whose usable width is 36, 18 or 9 bits. In the outbound direction it takes one 36-bit word from a FIFO read port and hands it out as one, two or four pieces. In the inbound direction it collects one, two or four pieces from the external port and writes the finished 36-bit word into the other FIFO's write port. Both sides use a valid/ready handshake: a transfer happens on a rising clock edge where both are high.

Two configuration inputs are captured while reset is held: a width code and a byte-order flag. In the narrow widths, the flag decides whether the most significant or the least significant piece of a word moves first. In the full width, data passes through unchanged. A reset throws away any word that is partly sent or partly built.

Top module: `bm_width_adapter`

## Requirements
- R1: `cfg_size_i` and `cfg_big_i` are captured on every clock edge where `rst_n` is low. Changing them while `rst_n` is high has no effect on any output.
- R2: Width code 2'b00 (and the spare code 2'b11) selects the 36-bit mode. In this mode each outbound FIFO word is presented whole as one transfer, and each accepted inbound transfer becomes one whole FIFO word.
- R3: Width code 2'b01 selects 18-bit pieces and 2'b10 selects 9-bit pieces. Each outbound word is emitted as 2 or 4 pieces on `nar_rd_data_o[W-1:0]`. With `cfg_big_i`=1 the pieces go from the most significant down (bits 35:27 or 35:18 first). With `cfg_big_i`=0 they go from the least significant up.
- R4: In the narrow modes the inbound pieces are taken from `nar_wr_data_i[W-1:0]`. They are placed into the word in the same order as in R3, and the completed word appears on `wfifo_data_o`.
- R5: In the 36-bit mode, `cfg_big_i` has no effect on data in either direction.
- R6: In the narrow modes, the output bits above the piece width read as zero. Input bits above the piece width are ignored.
- R7: `rfifo_pop_o` is high only when `rfifo_valid_i` is high and no piece is held, or when the last piece of the held word is being transferred. `nar_rd_valid_o` is high exactly while a piece is held.
- R8: `wfifo_valid_o` rises only in the cycle after the final piece of a word is accepted. It stays high, with the data stable, until `wfifo_ready_i` is high. `nar_wr_ready_o` is high when no finished word is pending or when `wfifo_ready_i` is high.
- R9: While `nar_rd_valid_o` is high and `nar_rd_ready_i` is low, the outbound piece stays unchanged on the next cycle.
- R10: Reset discards any partly emitted or partly assembled word. In the first cycle after reset, `nar_rd_valid_o` and `wfifo_valid_o` are low and `nar_wr_ready_o` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset; configuration is captured while it is low |
| cfg_size_i | input | 2 | Width code: 00 = 36, 01 = 18, 10 = 9, 11 = 36 |
| cfg_big_i | input | 1 | 1 = most significant piece first, 0 = least significant first |
| rfifo_data_i | input | 36 | Head word of the outbound FIFO |
| rfifo_valid_i | input | 1 | Outbound FIFO has a word |
| rfifo_pop_o | output | 1 | Takes the head word this cycle |
| nar_rd_data_o | output | 36 | Outbound piece, zero-extended |
| nar_rd_valid_o | output | 1 | Outbound piece available |
| nar_rd_ready_i | input | 1 | External side accepts the piece |
| nar_wr_data_i | input | 36 | Inbound piece in the low bits |
| nar_wr_valid_i | input | 1 | Inbound piece offered |
| nar_wr_ready_o | output | 1 | Block accepts the inbound piece |
| wfifo_data_o | output | 36 | Assembled word for the inbound FIFO |
| wfifo_valid_o | output | 1 | Assembled word pending |
| wfifo_ready_i | input | 1 | Inbound FIFO takes the word |

## Verification
The hardest case to reach from the ports is a reset that arrives while both directions are in the middle of a word: some pieces of the held outbound word have already been sent, and some inbound pieces have already been collected. The bench runs the flow with random handshake gaps. It watches its own model until the held outbound word has two or three pieces left and the inbound assembly holds one to three pieces. At that point it resets with a different width code and checks that neither half-finished word leaks into the traffic that follows. A second hard case is a stalled last piece that meets a waiting FIFO word. The random back-pressure on both handshakes produces this case many times.

// File: rtl/bm_pkg.sv
package bm_pkg;

    localparam int unsigned DATA_W = 36;

    typedef enum logic [1:0] {
        SZ_FULL    = 2'b00,
        SZ_HALF    = 2'b01,
        SZ_QUARTER = 2'b10,
        SZ_SPARE   = 2'b11
    } size_e;

    typedef struct packed {
        size_e size;
        logic  big;
    } cfg_t;

    // number of external transfers per internal word
    function automatic logic [2:0] pieces_of(size_e s);
        case (s)
            SZ_HALF:    return 3'd2;
            SZ_QUARTER: return 3'd4;
            default:    return 3'd1;
        endcase
    endfunction

    // lane (piece position inside the word) for transfer number idx
    function automatic logic [1:0] lane_of(logic [1:0] idx, size_e s, logic big);
        logic [2:0] n;
        n = pieces_of(s);
        if (!big) return idx;
        return 2'(n - 3'd1 - {1'b0, idx});
    endfunction

endpackage

// File: rtl/bm_unpack.sv
module bm_unpack
    import bm_pkg::*;
#(
    parameter int unsigned WORD_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic [WORD_W-1:0] fifo_data,
    input  logic              fifo_valid,
    output logic              fifo_pop,
    output logic [WORD_W-1:0] port_data,
    output logic              port_valid,
    input  logic              port_ready
);
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned QTR_W  = WORD_W / 4;

    typedef struct packed {
        logic [WORD_W-1:0] word;
        logic [1:0]        idx;
        logic              valid;
    } ustate_t;

    ustate_t s_q, s_d;
    logic [2:0] n_pieces;
    logic [1:0] lane;
    logic       last, fire;

    always_comb begin
        n_pieces = pieces_of(cfg.size);
        last     = ({1'b0, s_q.idx} == (n_pieces - 3'd1));
        fire     = s_q.valid && port_ready;
        fifo_pop = fifo_valid && (!s_q.valid || (fire && last));
        lane     = lane_of(s_q.idx, cfg.size, cfg.big);

        s_d = s_q;
        if (fifo_pop) begin
            s_d.word  = fifo_data;
            s_d.valid = 1'b1;
            s_d.idx   = '0;
        end else if (fire) begin
            if (last) begin
                s_d.valid = 1'b0;
                s_d.idx   = '0;
            end else begin
                s_d.idx = s_q.idx + 2'd1;
            end
        end

        port_data = '0;
        case (cfg.size)
            SZ_HALF:    port_data[HALF_W-1:0] = s_q.word[int'(lane[0]) * HALF_W +: HALF_W];
            SZ_QUARTER: port_data[QTR_W-1:0]  = s_q.word[int'(lane) * QTR_W +: QTR_W];
            default:    port_data             = s_q.word;
        endcase
        port_valid = s_q.valid;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bm_pack.sv
module bm_pack
    import bm_pkg::*;
#(
    parameter int unsigned WORD_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  cfg_t              cfg,
    input  logic [WORD_W-1:0] port_data,
    input  logic              port_valid,
    output logic              port_ready,
    output logic [WORD_W-1:0] fifo_data,
    output logic              fifo_valid,
    input  logic              fifo_ready
);
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned QTR_W  = WORD_W / 4;

    typedef struct packed {
        logic [WORD_W-1:0] acc;
        logic [WORD_W-1:0] out;
        logic [1:0]        idx;
        logic              full;
    } pstate_t;

    pstate_t s_q, s_d;
    logic [2:0]        n_pieces;
    logic [1:0]        lane;
    logic              last, take;
    logic [WORD_W-1:0] merged;

    always_comb begin
        n_pieces   = pieces_of(cfg.size);
        last       = ({1'b0, s_q.idx} == (n_pieces - 3'd1));
        lane       = lane_of(s_q.idx, cfg.size, cfg.big);
        port_ready = !s_q.full || fifo_ready;
        take       = port_valid && port_ready;

        merged = s_q.acc;
        case (cfg.size)
            SZ_HALF:    merged[int'(lane[0]) * HALF_W +: HALF_W] = port_data[HALF_W-1:0];
            SZ_QUARTER: merged[int'(lane) * QTR_W +: QTR_W]      = port_data[QTR_W-1:0];
            default:    merged                                   = port_data;
        endcase

        s_d = s_q;
        if (s_q.full && fifo_ready) s_d.full = 1'b0;
        if (take) begin
            if (last) begin
                s_d.out  = merged;
                s_d.full = 1'b1;
                s_d.acc  = '0;
                s_d.idx  = '0;
            end else begin
                s_d.acc = merged;
                s_d.idx = s_q.idx + 2'd1;
            end
        end

        fifo_data  = s_q.out;
        fifo_valid = s_q.full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

endmodule

// File: rtl/bm_width_adapter.sv
module bm_width_adapter
    import bm_pkg::*;
#(
    parameter int unsigned WORD_W = DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [1:0]        cfg_size_i,
    input  logic              cfg_big_i,
    input  logic [WORD_W-1:0] rfifo_data_i,
    input  logic              rfifo_valid_i,
    output logic              rfifo_pop_o,
    output logic [WORD_W-1:0] nar_rd_data_o,
    output logic              nar_rd_valid_o,
    input  logic              nar_rd_ready_i,
    input  logic [WORD_W-1:0] nar_wr_data_i,
    input  logic              nar_wr_valid_i,
    output logic              nar_wr_ready_o,
    output logic [WORD_W-1:0] wfifo_data_o,
    output logic              wfifo_valid_o,
    input  logic              wfifo_ready_i
);
    cfg_t cfg_q, cfg_d;

    always_comb begin
        cfg_d = cfg_q;
    end

    // configuration is only loaded while reset is held
    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '{size: size_e'(cfg_size_i), big: cfg_big_i};
        else        cfg_q <= cfg_d;
    end

    bm_unpack #(.WORD_W(WORD_W)) unpack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .fifo_data  (rfifo_data_i),
        .fifo_valid (rfifo_valid_i),
        .fifo_pop   (rfifo_pop_o),
        .port_data  (nar_rd_data_o),
        .port_valid (nar_rd_valid_o),
        .port_ready (nar_rd_ready_i)
    );

    bm_pack #(.WORD_W(WORD_W)) pack_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg        (cfg_q),
        .port_data  (nar_wr_data_i),
        .port_valid (nar_wr_valid_i),
        .port_ready (nar_wr_ready_o),
        .fifo_data  (wfifo_data_o),
        .fifo_valid (wfifo_valid_o),
        .fifo_ready (wfifo_ready_i)
    );

endmodule

// File: rtl/bm_width_adapter_chk.sv
module bm_width_adapter_chk
    import bm_pkg::*;
#(
    parameter int unsigned WORD_W = DATA_W
) (
    input logic              clk,
    input logic              rst_n,
    input cfg_t              cfg_q,
    input logic              rfifo_valid_i,
    input logic              rfifo_pop_o,
    input logic [WORD_W-1:0] nar_rd_data_o,
    input logic              nar_rd_valid_o,
    input logic              nar_rd_ready_i,
    input logic              nar_wr_ready_o,
    input logic [WORD_W-1:0] wfifo_data_o,
    input logic              wfifo_valid_o,
    input logic              wfifo_ready_i
);
    localparam int unsigned HALF_W = WORD_W / 2;
    localparam int unsigned QTR_W  = WORD_W / 4;

    // R9
    rd_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nar_rd_valid_o && !nar_rd_ready_i |=> nar_rd_valid_o && $stable(nar_rd_data_o));

    // R8
    wr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wfifo_valid_o && !wfifo_ready_i |=> wfifo_valid_o && $stable(wfifo_data_o));

    // R8
    wr_accept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        wfifo_valid_o && !wfifo_ready_i |-> !nar_wr_ready_o);

    // R6
    half_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nar_rd_valid_o && cfg_q.size == SZ_HALF |-> nar_rd_data_o[WORD_W-1:HALF_W] == '0);

    // R6
    quarter_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nar_rd_valid_o && cfg_q.size == SZ_QUARTER |-> nar_rd_data_o[WORD_W-1:QTR_W] == '0);

    // R7
    pop_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfifo_pop_o |-> rfifo_valid_i);

    // R7
    pop_drain_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rfifo_pop_o && nar_rd_valid_o |-> nar_rd_ready_i);

    // R10
    rst_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> !nar_rd_valid_o && !wfifo_valid_o && nar_wr_ready_o);

    // R1
    cfg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rst_n) |-> $stable(cfg_q));

endmodule

bind bm_width_adapter bm_width_adapter_chk #(.WORD_W(WORD_W)) chk_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .cfg_q          (cfg_q),
    .rfifo_valid_i  (rfifo_valid_i),
    .rfifo_pop_o    (rfifo_pop_o),
    .nar_rd_data_o  (nar_rd_data_o),
    .nar_rd_valid_o (nar_rd_valid_o),
    .nar_rd_ready_i (nar_rd_ready_i),
    .nar_wr_ready_o (nar_wr_ready_o),
    .wfifo_data_o   (wfifo_data_o),
    .wfifo_valid_o  (wfifo_valid_o),
    .wfifo_ready_i  (wfifo_ready_i)
);

// File: tb/bm_width_adapter_tb_top.sv
`timescale 1ns/1ps
module bm_width_adapter_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cfg_size_i = 2'b00;
    logic        cfg_big_i = 1'b0;
    logic [35:0] rfifo_data_i = '0;
    logic        rfifo_valid_i = 1'b0;
    logic        rfifo_pop_o;
    logic [35:0] nar_rd_data_o;
    logic        nar_rd_valid_o;
    logic        nar_rd_ready_i = 1'b0;
    logic [35:0] nar_wr_data_i = '0;
    logic        nar_wr_valid_i = 1'b0;
    logic        nar_wr_ready_o;
    logic [35:0] wfifo_data_o;
    logic        wfifo_valid_o;
    logic        wfifo_ready_i = 1'b0;

    always #2.5 clk = ~clk;

    bm_width_adapter dut_i (
        .clk            (clk),
        .rst_n          (rst_n),
        .cfg_size_i     (cfg_size_i),
        .cfg_big_i      (cfg_big_i),
        .rfifo_data_i   (rfifo_data_i),
        .rfifo_valid_i  (rfifo_valid_i),
        .rfifo_pop_o    (rfifo_pop_o),
        .nar_rd_data_o  (nar_rd_data_o),
        .nar_rd_valid_o (nar_rd_valid_o),
        .nar_rd_ready_i (nar_rd_ready_i),
        .nar_wr_data_i  (nar_wr_data_i),
        .nar_wr_valid_i (nar_wr_valid_i),
        .nar_wr_ready_o (nar_wr_ready_o),
        .wfifo_data_o   (wfifo_data_o),
        .wfifo_valid_o  (wfifo_valid_o),
        .wfifo_ready_i  (wfifo_ready_i)
    );

    int errors = 0;
    int checks = 0;

    // reference model state
    logic [35:0] src_q[$];
    logic [35:0] held[$];
    logic [35:0] pend[$];
    logic [35:0] wacc;
    int          wcnt;
    int          m_size;
    bit          m_big;
    bit          wiggle_on;
    bit          post_rst;
    bit          prev_stall;
    logic [35:0] prev_data;

    function automatic int n_of(int s);
        return (s == 1) ? 2 : (s == 2) ? 4 : 1;
    endfunction

    function automatic int lane_pos(int k, int n, bit big);
        return big ? (n - 1 - k) : k;
    endfunction

    task automatic chk(bit ok, string tag, logic [35:0] act, logic [35:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic string rd_tag();
        if (wiggle_on) return "R1";
        if (n_of(m_size) == 1) return m_big ? "R5" : "R2";
        return "R3";
    endfunction

    function automatic string wr_tag();
        if (wiggle_on) return "R1";
        if (n_of(m_size) == 1) return m_big ? "R5" : "R2";
        return "R4";
    endfunction

    task automatic load_pieces(logic [35:0] w);
        int n = n_of(m_size);
        int pw = 36 / n;
        held.delete();
        for (int k = 0; k < n; k++) begin
            logic [35:0] p = '0;
            int ln = lane_pos(k, n, m_big);
            for (int b = 0; b < pw; b++) p[b] = w[ln * pw + b];
            held.push_back(p);
        end
    endtask

    task automatic observe();
        bit          exp_valid, hs, exp_pop, exp_wready, take;
        int          n = n_of(m_size);
        int          pw = 36 / n;
        logic [35:0] zmask;
        if (post_rst) begin
            // R10: post-reset state
            chk(!nar_rd_valid_o, "R10", {35'b0, nar_rd_valid_o}, 36'd0);
            chk(!wfifo_valid_o, "R10", {35'b0, wfifo_valid_o}, 36'd0);
            chk(nar_wr_ready_o, "R10", {35'b0, nar_wr_ready_o}, 36'd1);
            post_rst = 1'b0;
        end
        // read direction
        exp_valid = held.size() > 0;
        chk(nar_rd_valid_o == exp_valid, "R7", {35'b0, nar_rd_valid_o}, {35'b0, exp_valid});
        hs = exp_valid && nar_rd_ready_i;
        exp_pop = rfifo_valid_i && (held.size() == 0 || (hs && held.size() == 1));
        chk(rfifo_pop_o == exp_pop, "R7", {35'b0, rfifo_pop_o}, {35'b0, exp_pop});
        if (exp_valid) begin
            chk(nar_rd_data_o == held[0], rd_tag(), nar_rd_data_o, held[0]);
            if (n > 1) begin
                zmask = '1;
                zmask = zmask << pw;
                chk((nar_rd_data_o & zmask) == '0, "R6", nar_rd_data_o & zmask, 36'd0);
            end
            if (prev_stall) chk(nar_rd_data_o == prev_data, "R9", nar_rd_data_o, prev_data);
        end
        prev_stall = exp_valid && !nar_rd_ready_i;
        prev_data  = nar_rd_data_o;
        if (hs) void'(held.pop_front());
        if (exp_pop) load_pieces(src_q.pop_front());

        // write direction
        exp_wready = (pend.size() == 0) || wfifo_ready_i;
        chk(nar_wr_ready_o == exp_wready, "R8", {35'b0, nar_wr_ready_o}, {35'b0, exp_wready});
        chk(wfifo_valid_o == (pend.size() > 0), "R8", {35'b0, wfifo_valid_o}, {35'b0, pend.size() > 0});
        if (pend.size() > 0) begin
            chk(wfifo_data_o == pend[0], (n > 1) ? "R6" : wr_tag(), wfifo_data_o, pend[0]);
            if (wfifo_ready_i) void'(pend.pop_front());
        end
        take = nar_wr_valid_i && exp_wready;
        if (take) begin
            int ln = lane_pos(wcnt, n, m_big);
            for (int b = 0; b < pw; b++) wacc[ln * pw + b] = nar_wr_data_i[b];
            wcnt++;
            if (wcnt == n) begin
                pend.push_back(wacc);
                wacc = '0;
                wcnt = 0;
            end
        end
    endtask

    task automatic step(bit wig);
        @(negedge clk);
        rfifo_valid_i  = (src_q.size() > 0) && ($urandom_range(0, 3) != 0);
        rfifo_data_i   = (src_q.size() > 0) ? src_q[0] : 36'd0;
        nar_rd_ready_i = ($urandom_range(0, 2) != 0);
        nar_wr_valid_i = ($urandom_range(0, 2) != 0);
        nar_wr_data_i  = {4'($urandom), 32'($urandom)};
        wfifo_ready_i  = ($urandom_range(0, 2) != 0);
        if (wig) begin
            cfg_size_i = 2'($urandom);
            cfg_big_i  = 1'($urandom);
        end
        #1;
        observe();
    endtask

    task automatic do_reset(int s, bit big);
        @(negedge clk);
        rst_n          = 1'b0;
        cfg_size_i     = 2'(s);
        cfg_big_i      = big;
        rfifo_valid_i  = 1'b0;
        nar_wr_valid_i = 1'b0;
        nar_rd_ready_i = 1'b0;
        wfifo_ready_i  = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_size = s;
        m_big  = big;
        held.delete();
        pend.delete();
        wacc = '0;
        wcnt = 0;
        prev_stall = 1'b0;
        post_rst = 1'b1;
    endtask

    task automatic fill(int cnt);
        for (int i = 0; i < cnt; i++) src_q.push_back({4'($urandom), 32'($urandom)});
    endtask

    initial begin
        int sizes[7] = '{0, 0, 1, 1, 2, 2, 3};
        bit bigs[7]  = '{0, 1, 1, 0, 1, 0, 1};
        wacc = '0;
        wcnt = 0;
        wiggle_on = 1'b0;
        post_rst = 1'b0;
        prev_stall = 1'b0;
        prev_data = '0;
        for (int c = 0; c < 7; c++) begin
            do_reset(sizes[c], bigs[c]);
            fill(24);
            repeat (250) step(1'b0);
        end
        // R1: configuration inputs move while running
        do_reset(2, 1'b1);
        fill(24);
        wiggle_on = 1'b1;
        repeat (250) step(1'b1);
        wiggle_on = 1'b0;
        // R10: reset in the middle of both directions
        do_reset(2, 1'b0);
        src_q.delete();
        fill(30);
        for (int i = 0; i < 200; i++) begin
            step(1'b0);
            if ((held.size() == 2 || held.size() == 3) && wcnt > 0) break;
        end
        do_reset(1, 1'b1);
        repeat (250) step(1'b0);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        #(200000 * 5);
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule